// File: doc/BRIEF.md
# Sixteen-to-One Sigma-Delta Decimation Chain

This block turns the 4-bit code stream of an oversampled sigma-delta modulator into a slower, wider signed word. It accepts one code per clock and emits one result per sixteen clocks. The rate reduction is split across three dissimilar stages. A fourth-order cascaded integrator-comb (CIC) section first brings the rate down by eight. A short symmetric FIR then runs at that intermediate rate and undoes the CIC passband droop; it does not decimate. A seven-tap half-band FIR applies the last factor of two.

Every stage uses fixed integer coefficients and integer arithmetic, so the output is bit-exact and can be reproduced with plain integer math. A control module keeps a phase counter and the fill state of each delay line. It drives the datapath through a small bundle of strobes, and no output is flagged valid until every delay line holds real samples.

Top module: `sd_decim16`

## Requirements
- R1: `sampleIn` is a 4-bit two's-complement code in the range -8..7. It is captured on every rising clock edge once `rst` is low; sample 0 is the one present at the first edge after release.
- R2: The first stage has four integrators at the input rate and four combs with differential delay 1, all 16 bits wide with wraparound. Integrator k adds the previous value of integrator k-1. On every eighth edge (edges 7, 15, 23, ... after release) the last integrator is differenced four times, and the result is the decimated value m. A constant code c settles to an output of c·4096.
- R3: The first four decimated values (m = 0..3) only fill the comb delays and are not passed on.
- R4: The compensation FIR computes -1·(s[i]+s[i-4]) - 2·(s[i-1]+s[i-3]) + 22·s[i-2] over the passed CIC values s, adds 8, shifts right arithmetically by 4, and saturates to 16-bit signed (-32768..32767).
- R5: The compensation FIR gives its first result only once five CIC values are present (i ≥ 4). It makes exactly one result per CIC value after that.
- R6: The half-band FIR computes -(t[k]+t[k-6]) + 9·(t[k-2]+t[k-4]) + 16·t[k-3] over the compensated values t, adds 16, and shifts right arithmetically by 5 into 18 bits. It fires only for odd k ≥ 7, and its zero taps use no multiply.
- R7: `outValid` is a single-cycle pulse, and consecutive pulses are exactly 16 clock edges apart.
- R8: The first `outValid` pulse is set by edge 129 after reset release, counting the first edge as 0.
- R9: A synchronous `rst` clears every integrator, comb, delay line and counter. While it is high, `outValid` and `outData` are 0. A stream sent after a mid-run reset gives the same results as one sent from power-up.
- R10: `outData` holds its value between `outValid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one code per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 4 | Signed modulator code |
| outData | output | 18 | Signed decimated result |
| outValid | output | 1 | One-cycle strobe marking a new `outData` |

## Verification
All sixteen constant codes are applied. They pin the DC gain of the whole chain to exactly 4096 per code step, and the extreme codes test the 16-bit CIC wrap and the saturation edge. Four more streams compare every output with an integer model computed in the bench. An alternating ±code stream checks high-frequency rejection and comb arithmetic. A ramp through all codes checks sign handling. A pseudo-random stream checks general tap alignment. A slow full-scale square wave drives the compensation stage into clipping. Each run starts from a reset taken in the middle of the previous one, and it also checks first-output latency, pulse spacing and holding of the output between pulses.

// File: rtl/sd_decim16_pkg.sv
package sd_decim16_pkg;
  localparam int IN_W      = 4;
  localparam int CIC_R     = 8;
  localparam int CIC_N     = 4;
  localparam int CIC_W     = IN_W + CIC_N * $clog2(CIC_R);
  localparam int COMP_W    = 16;
  localparam int OUT_W     = 18;
  localparam int COMP_TAPS = 5;
  localparam int COMP_MID  = COMP_TAPS / 2;
  localparam int COMP_SHIFT = 4;
  localparam int COMP_ROUND = 1 << (COMP_SHIFT - 1);
  localparam int COMP_MAX  = (1 << (COMP_W - 1)) - 1;
  localparam int COMP_MIN  = -(1 << (COMP_W - 1));
  localparam int COMP_COEF [COMP_TAPS] = '{-1, -2, 22, -2, -1};
  localparam int HB_TAPS   = 7;
  localparam int HB_MID    = HB_TAPS / 2;
  localparam int HB_SHIFT  = 5;
  localparam int HB_ROUND  = 1 << (HB_SHIFT - 1);
  localparam int HB_COEF [HB_TAPS] = '{-1, 0, 9, 16, 9, 0, -1};
  // edge index (from release) on which the first result is registered
  localparam int FIRST_OUT_EDGE = CIC_R * (CIC_N + COMP_TAPS + HB_TAPS - 1) + CIC_R + 1;

  typedef struct packed {
    logic dump;       // CIC comb update at decimated rate
    logic cicEmit;    // register a CIC result that leaves the stage
    logic compShift;  // advance compensation delay line
    logic compEmit;   // register a compensation result
    logic hbShift;    // advance half-band delay line
    logic hbEmit;     // register a half-band result
  } stb_t;
endpackage

// File: rtl/sd_decim16_ctrl.sv
module sd_decim16_ctrl
  import sd_decim16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output stb_t stb,
  output logic outValid
);
  localparam int PH_W   = $clog2(CIC_R);
  localparam int CF_W   = $clog2(CIC_N + 1);
  localparam int KF_W   = $clog2(COMP_TAPS);
  localparam int HF_W   = $clog2(HB_TAPS);

  logic [PH_W-1:0] phase;
  logic [CF_W-1:0] cicFill;
  logic [KF_W-1:0] compFill;
  logic [HF_W-1:0] hbFill;
  logic hbOdd, cicV, compV;

  always_comb begin
    stb.dump      = (phase == PH_W'(CIC_R - 1));
    stb.cicEmit   = stb.dump && (cicFill == CF_W'(CIC_N));
    stb.compShift = cicV;
    stb.compEmit  = cicV && (compFill == KF_W'(COMP_TAPS - 1));
    stb.hbShift   = compV;
    stb.hbEmit    = compV && hbOdd && (hbFill == HF_W'(HB_TAPS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0; cicFill <= '0; compFill <= '0; hbFill <= '0;
      hbOdd <= 1'b0; cicV <= 1'b0; compV <= 1'b0; outValid <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      if (stb.dump && cicFill != CF_W'(CIC_N)) cicFill <= cicFill + 1'b1;
      if (cicV && compFill != KF_W'(COMP_TAPS - 1)) compFill <= compFill + 1'b1;
      if (compV) begin
        hbOdd <= ~hbOdd;
        if (hbFill != HF_W'(HB_TAPS - 1)) hbFill <= hbFill + 1'b1;
      end
      cicV     <= stb.cicEmit;
      compV    <= stb.compEmit;
      outValid <= stb.hbEmit;
    end
  end
endmodule

// File: rtl/sd_decim16_dp.sv
module sd_decim16_dp
  import sd_decim16_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  stb_t                    stb,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [OUT_W-1:0] outData
);
  logic signed [CIC_W-1:0]  integ   [CIC_N];
  logic signed [CIC_W-1:0]  combIn  [CIC_N+1];
  logic signed [CIC_W-1:0]  combDly [CIC_N];
  logic signed [CIC_W-1:0]  cicOut;
  logic signed [CIC_W-1:0]  compTap [COMP_TAPS-1];
  logic signed [CIC_W-1:0]  compWin [COMP_TAPS];
  logic signed [COMP_W-1:0] compOut;
  logic signed [COMP_W-1:0] hbTap   [HB_TAPS-1];
  logic signed [COMP_W-1:0] hbWin   [HB_TAPS];
  int compAcc, compRnd, compSat, hbAcc;

  // integrators at input rate
  for (genvar g = 0; g < CIC_N; g++) begin : gInteg
    logic signed [CIC_W-1:0] addend;
    if (g == 0) begin : gFirst
      assign addend = CIC_W'(sampleIn);
    end else begin : gRest
      assign addend = integ[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) integ[g] <= '0;
      else     integ[g] <= integ[g] + addend;
    end
  end

  // combs at decimated rate
  assign combIn[0] = integ[CIC_N-1];
  for (genvar g = 0; g < CIC_N; g++) begin : gComb
    assign combIn[g+1] = combIn[g] - combDly[g];
    always_ff @(posedge clk) begin
      if (rst)           combDly[g] <= '0;
      else if (stb.dump) combDly[g] <= combIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              cicOut <= '0;
    else if (stb.cicEmit) cicOut <= combIn[CIC_N];
  end

  // compensation FIR delay line
  assign compWin[0] = cicOut;
  for (genvar g = 0; g < COMP_TAPS-1; g++) begin : gCompTap
    assign compWin[g+1] = compTap[g];
    always_ff @(posedge clk) begin
      if (rst)                compTap[g] <= '0;
      else if (stb.compShift) compTap[g] <= compWin[g];
    end
  end

  always_comb begin
    compAcc = COMP_COEF[COMP_MID] * int'(compWin[COMP_MID]);
    for (int i = 0; i < COMP_MID; i++)
      compAcc += COMP_COEF[i] * (int'(compWin[i]) + int'(compWin[COMP_TAPS-1-i]));
    compRnd = (compAcc + COMP_ROUND) >>> COMP_SHIFT;
    if (compRnd > COMP_MAX)      compSat = COMP_MAX;
    else if (compRnd < COMP_MIN) compSat = COMP_MIN;
    else                         compSat = compRnd;
  end

  always_ff @(posedge clk) begin
    if (rst)               compOut <= '0;
    else if (stb.compEmit) compOut <= COMP_W'(compSat);
  end

  // half-band delay line
  assign hbWin[0] = compOut;
  for (genvar g = 0; g < HB_TAPS-1; g++) begin : gHbTap
    assign hbWin[g+1] = hbTap[g];
    always_ff @(posedge clk) begin
      if (rst)              hbTap[g] <= '0;
      else if (stb.hbShift) hbTap[g] <= hbWin[g];
    end
  end

  always_comb begin
    hbAcc = HB_COEF[HB_MID] * int'(hbWin[HB_MID]);
    for (int i = 0; i < HB_MID; i++)
      if (((HB_MID - i) % 2) != 0)  // even-offset taps are zero: skipped
        hbAcc += HB_COEF[i] * (int'(hbWin[i]) + int'(hbWin[HB_TAPS-1-i]));
  end

  always_ff @(posedge clk) begin
    if (rst)             outData <= '0;
    else if (stb.hbEmit) outData <= OUT_W'((hbAcc + HB_ROUND) >>> HB_SHIFT);
  end
endmodule

// File: rtl/sd_decim16.sv
module sd_decim16
  import sd_decim16_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  sampleIn,
  output logic signed [OUT_W-1:0] outData,
  output logic                    outValid
);
  stb_t stb;

  sd_decim16_ctrl ctrl (
    .clk(clk), .rst(rst), .stb(stb), .outValid(outValid)
  );

  sd_decim16_dp dp (
    .clk(clk), .rst(rst), .stb(stb), .sampleIn(sampleIn), .outData(outData)
  );
endmodule

// File: rtl/sd_decim16_chk.sv
module sd_decim16_chk
  import sd_decim16_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] outData
);
  localparam int GAP = 2 * CIC_R;
  localparam int SINCE_CAP = FIRST_OUT_EDGE + 1;
  localparam int SW = $clog2(SINCE_CAP + 1);
  localparam int GW = $clog2(GAP + 1);

  logic [SW-1:0] sinceRst;
  logic [GW-1:0] gapCnt;
  logic          seenOne;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0; gapCnt <= '0; seenOne <= 1'b0;
    end else begin
      if (sinceRst != SW'(SINCE_CAP)) sinceRst <= sinceRst + 1'b1;
      if (outValid) begin
        gapCnt <= '0; seenOne <= 1'b1;
      end else if (gapCnt != GW'(GAP)) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> sinceRst == SW'(SINCE_CAP)); // R8
  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
    (outValid && seenOne) |-> gapCnt == GW'(GAP - 1)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0)); // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R10
endmodule

bind sd_decim16 sd_decim16_chk chk (
  .clk(clk), .rst(rst), .outValid(outValid), .outData(outData)
);

// File: tb/sd_decim16_test.sv
module sd_decim16_test;
  localparam int NS = 400;
  localparam int FIRST_SEEN = 130;
  localparam int NOBS = (NS - FIRST_SEEN) / 16 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [3:0]  sampleIn = '0;
  logic signed [17:0] outData;
  logic outValid;
  int total = 0;
  int bad = 0;

  sd_decim16 uut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .outData(outData), .outValid(outValid)
  );

  always #10 clk = ~clk;

  int xin [NS];
  int ex  [64];
  int nEx;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int w16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  task automatic buildModel();
    longint i1 = 0, i2 = 0, i3 = 0, i4 = 0;
    int i4a [NS+1];
    int prev [4];
    int s [64];
    int t [64];
    int nS = 0, nT = 0;
    i4a[0] = 0;
    for (int j = 0; j < NS; j++) begin
      longint n1, n2, n3, n4;
      n4 = w16(i4 + i3); n3 = w16(i3 + i2); n2 = w16(i2 + i1); n1 = w16(i1 + xin[j]);
      i1 = n1; i2 = n2; i3 = n3; i4 = n4;
      i4a[j+1] = int'(i4);
    end
    for (int st = 0; st < 4; st++) prev[st] = 0;
    for (int m = 0; 8*m + 7 <= NS; m++) begin       // R2 comb chain
      int c;
      c = i4a[8*m + 7];
      for (int st = 0; st < 4; st++) begin
        int d;
        d = w16(longint'(c) - prev[st]);
        prev[st] = c;
        c = d;
      end
      if (m >= 4) begin s[nS] = c; nS++; end        // R3 fill
    end
    for (int i = 4; i < nS; i++) begin              // R4, R5
      int acc, r;
      acc = -(s[i] + s[i-4]) - 2*(s[i-1] + s[i-3]) + 22*s[i-2];
      r = (acc + 8) >>> 4;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      t[nT] = r; nT++;
    end
    nEx = 0;
    for (int k = 7; k < nT; k += 2) begin           // R6
      int acc;
      acc = -(t[k] + t[k-6]) + 9*(t[k-2] + t[k-4]) + 16*t[k-3];
      ex[nEx] = (acc + 16) >>> 5; nEx++;
    end
  endtask

  task automatic runPattern(input int kind);
    int got, lastEdge, lastData;
    bit holdOk;
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int n = 0; n < NS; n++) begin
      case (kind)
        16: xin[n] = (n % 2 == 0) ? 7 : -8;
        17: xin[n] = (n % 16) - 8;
        18: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          xin[n] = int'($signed(lfsr[3:0]));
        end
        19: xin[n] = ((n / 64) % 2 == 0) ? -8 : 7;
        default: xin[n] = kind - 8;
      endcase
    end
    buildModel();
    // reset mid-stream (previous run left state behind)
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outData == '0, "R9 reset state", int'(outData), 0);
    rst = 1'b0;
    sampleIn = 4'(xin[0]);                          // R1 sample 0
    got = 0; lastEdge = 0; lastData = 0; holdOk = 1'b1;
    for (int n = 1; n <= NS; n++) begin
      @(negedge clk);
      if (outValid) begin
        if (got == 0) check(n == FIRST_SEEN, "R8 first output edge", n, FIRST_SEEN);
        else          check(n - lastEdge == 16, "R7 pulse spacing", n - lastEdge, 16);
        if (got < nEx)
          check(int'(outData) == ex[got], "R6 chain output vs model", int'(outData), ex[got]);
        lastEdge = n; lastData = int'(outData); got++;
      end else if (got > 0 && int'(outData) != lastData) begin
        holdOk = 1'b0;
      end
      if (n < NS) sampleIn = 4'(xin[n]);
    end
    check(got == NOBS, "R5 output count", got, NOBS);
    check(holdOk, "R10 data held between pulses", int'(outData), lastData);
    if (kind < 16)
      check(lastData == (kind - 8) * 4096, "R2 DC gain", lastData, (kind - 8) * 4096);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(outValid == 1'b0 && outData == '0, "R9 power-up reset", int'(outData), 0);
    for (int k = 0; k < 20; k++) runPattern(k);    // R1..R4 via all streams
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule